// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

The block drives four independent pulse outputs. Each channel is set up by a single 32-bit control word. The word carries a run bit, a 15-bit on-time and a 13-bit clock prescaler. The prescaler turns the core clock into a slower tick. An 8-bit counter steps once per tick through a fixed period of 256 ticks. The output is high while that counter is below the programmed on-time.

Software reaches the control words through a word-addressed write port and a combinational read port. Every channel owns four consecutive words. Only the first of the four is implemented; the other three are reserved.

On-time and prescaler changes made while a channel runs are held in a shadow copy until the current period ends, so a period is never cut short or stretched. Clearing the run bit is the one exception: it silences the output at once and parks the channel's counters at zero. The next enable then begins a fresh period.

Top module: `pwm_quad`

## Requirements
- R1: The four channels run independently; channel k drives `pwm_out[k]` only, and the settings of one channel never change the waveform of another.
- R2: Word address `addr` selects channel `addr[3:2]` and word `addr[1:0]` inside that channel's four-word slot. Word 0 is the control word. `rdata` shows the addressed word combinationally in the same cycle, and a write with `wr_en` high takes effect at the next rising clock edge.
- R3: Control bit 31 is the run bit. When a write clears it, the channel's output is low from that write edge onward, and its prescaler and period counter are held at zero. A later enable starts a new period at counter value 0, so the output is high in the first cycle whenever the on-time is nonzero.
- R4: Control bits 30:16 hold the on-time n. While the channel runs, each 256-tick period starts with n high ticks followed by 256-n low ticks.
- R5: An on-time of 0 keeps the output low for the whole period.
- R6: Any on-time of 256 or more keeps the output high for as long as the channel runs.
- R7: Control bits 12:0 hold the prescaler N. The period counter advances once every N core clocks, so one period lasts 256*N clocks and the high time is n*N clocks.
- R8: A prescaler value of 0 behaves exactly like a value of 1.
- R9: On-time and prescaler changes written while a channel runs do not apply until the next period boundary. A write that lands on the same edge as a period boundary applies to the period that starts at that edge.
- R10: Reads of the three reserved words return zero, and writes to them change nothing. Control bits 15:13 are not stored and read back as zero.
- R11: After reset every control word reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 4 | Word address: channel in bits 3:2, word in slot in bits 1:0 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| pwm_out | output | 4 | One pulse output per channel |

## Verification
Two events can fall on the same clock edge: a software write to a running channel's control word, and that channel's period boundary, where the shadow copy is reloaded. The bench provokes this by counting exactly 255 prescaled cycles after an enable at a prescaler of 1 and issuing the write on the 256th edge. It judges the result by counting high cycles over the following 256 cycles, which must match the newly written on-time rather than the old one. A second case writes in mid-period and checks that the old on-time still governs the rest of that period.

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [NCH-1:0] pwm_out
);

  localparam logic [31:0] KEEP = 32'hFFFF_1FFF;

  logic [NCH-1:0][31:0] ctrl, ctrl_nxt;
  logic [NCH-1:0][14:0] shd_w;
  logic [NCH-1:0][12:0] shd_d;
  logic [NCH-1:0][12:0] pre;
  logic [NCH-1:0][7:0]  cnt;
  logic [NCH-1:0]       en, tick, wrap;

  wire [CW-1:0] sel = addr[AW-1:2];
  wire          ctl_word = (addr[1:0] == 2'd0);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (ctl_word && sel == CW'(i)) rdata = ctrl[i];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [12:0] lim;
    assign lim     = (shd_d[i] == '0) ? '0 : shd_d[i] - 13'd1;
    assign en[i]   = ctrl[i][31];
    assign tick[i] = en[i] && (pre[i] >= lim);
    assign wrap[i] = tick[i] && (cnt[i] == 8'hFF);
    assign pwm_out[i] = en[i] && ({7'd0, cnt[i]} < shd_w[i]);

    always_comb begin
      ctrl_nxt[i] = ctrl[i];
      if (wr_en && ctl_word && sel == CW'(i)) ctrl_nxt[i] = wdata & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl[i]  <= '0;
        shd_w[i] <= '0;
        shd_d[i] <= '0;
        pre[i]   <= '0;
        cnt[i]   <= '0;
      end else begin
        ctrl[i] <= ctrl_nxt[i];
        if (!en[i]) begin
          pre[i]   <= '0;
          cnt[i]   <= '0;
          shd_w[i] <= ctrl_nxt[i][30:16];
          shd_d[i] <= ctrl_nxt[i][12:0];
        end else begin
          pre[i] <= tick[i] ? '0 : pre[i] + 13'd1;
          if (tick[i]) cnt[i] <= cnt[i] + 8'd1;
          if (wrap[i]) begin
            shd_w[i] <= ctrl_nxt[i][30:16];
            shd_d[i] <= ctrl_nxt[i][12:0];
          end
        end
      end
    end
  end

endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int NCH = 4,
  parameter int AW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [AW-1:0]        addr,
  input logic [31:0]          rdata,
  input logic [NCH-1:0]       pwm_out,
  input logic [NCH-1:0]       en,
  input logic [NCH-1:0]       wrap,
  input logic [NCH-1:0][7:0]  cnt,
  input logic [NCH-1:0][14:0] shd_w
);

  p_resv_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr[1:0] != 2'd0 |-> rdata == 32'd0);

  p_gap_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[15:13] == 3'd0);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |-> !pwm_out[i]);

    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] && !$past(en[i]) |-> cnt[i] == 8'd0);

    p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en[i] && shd_w[i] == 15'd0 |-> !pwm_out[i]);

    p_full_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en[i] && shd_w[i] >= 15'd256 |-> pwm_out[i]);

    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      en[i] && $past(en[i]) && !$past(wrap[i]) |-> $stable(shd_w[i]));
  end

endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata), .pwm_out(pwm_out),
  .en(en), .wrap(wrap), .cnt(cnt), .shd_w(shd_w)
);

// File: tb/tb_pwm_quad.sv
`timescale 1ns/1ps
module tb_pwm_quad;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_quad dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  function automatic logic [31:0] cw(bit e, int w, int d);
    return {e, w[14:0], 3'b000, d[12:0]};
  endfunction

  task automatic chk(string req, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(int ch, int word, logic [31:0] d);
    addr = {ch[1:0], word[1:0]}; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int ch, int word, output logic [31:0] d);
    addr = {ch[1:0], word[1:0]};
    #0.5 d = rdata;
  endtask

  task automatic count(int ch, int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      hi += pwm_out[ch];
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R11", pwm_out, 0, "outputs after reset");
    for (int c = 0; c < 4; c++) begin
      rd(c, 0, d);
      chk("R11", d, 0, "control word after reset");
    end
  endtask

  task automatic t_regs();
    logic [31:0] d; int hi;
    do_reset();
    wr(1, 0, 32'h0000_FFFF);
    rd(1, 0, d);
    chk("R10", d, 32'h0000_1FFF, "bits 15:13 read zero");
    wr(1, 2, 32'hFFFF_FFFF);
    rd(1, 2, d);
    chk("R10", d, 0, "reserved word reads zero");
    rd(1, 0, d);
    chk("R10", d, 32'h0000_1FFF, "reserved write leaves control");
    count(1, 20, hi);
    chk("R10", hi, 0, "reserved write leaves output idle");
    wr(2, 0, 32'hFFFF_FFFF);
    rd(2, 0, d);
    chk("R2", d, 32'hFFFF_1FFF, "control readback on channel 2");
    count(2, 2000, hi);
    chk("R6", hi, 2000, "on-time 0x7FFF always high");
  endtask

  task automatic t_duty();
    int hi;
    do_reset();
    wr(0, 0, cw(1, 64, 1));
    count(0, 256, hi);
    chk("R4", hi, 64, "n=64 high count");
    count(0, 256, hi);
    chk("R4", hi, 64, "n=64 second period");
    wr(0, 0, cw(0, 0, 0));
    @(negedge clk);
    wr(0, 0, cw(1, 256, 1));
    count(0, 512, hi);
    chk("R6", hi, 512, "n=256 always high");
    wr(0, 0, cw(0, 0, 0));
    @(negedge clk);
    wr(0, 0, cw(1, 0, 1));
    count(0, 512, hi);
    chk("R5", hi, 0, "n=0 always low");
  endtask

  task automatic t_div();
    int hi;
    do_reset();
    wr(3, 0, cw(1, 10, 3));
    count(3, 30, hi);
    chk("R7", hi, 30, "div=3 first 30 clocks high");
    count(3, 738, hi);
    chk("R7", hi, 0, "div=3 rest of period low");
    count(3, 768, hi);
    chk("R7", hi, 30, "div=3 next period");
    wr(3, 0, cw(0, 0, 0));
    @(negedge clk);
    wr(3, 0, cw(1, 5, 0));
    count(3, 5, hi);
    chk("R8", hi, 5, "div=0 first 5 clocks high");
    count(3, 251, hi);
    chk("R8", hi, 0, "div=0 period length 256");
  endtask

  task automatic t_disable();
    int hi;
    do_reset();
    wr(1, 0, cw(1, 200, 1));
    count(1, 10, hi);
    wr(1, 0, cw(0, 200, 1));
    chk("R3", pwm_out[1], 0, "low right after disable");
    count(1, 256, hi);
    chk("R3", hi, 0, "stays low while disabled");
    wr(1, 0, cw(1, 3, 1));
    chk("R3", pwm_out[1], 1, "re-enable starts new period high");
    count(1, 256, hi);
    chk("R3", hi, 3, "re-enable period from counter 0");
  endtask

  task automatic t_midperiod();
    int hi;
    do_reset();
    wr(2, 0, cw(1, 200, 1));
    count(2, 50, hi);
    wr(2, 0, cw(1, 20, 1));
    count(2, 205, hi);
    chk("R9", hi, 149, "old on-time holds to period end");
    count(2, 256, hi);
    chk("R9", hi, 20, "new on-time next period");
  endtask

  task automatic t_boundary();
    int hi;
    do_reset();
    wr(0, 0, cw(1, 200, 1));
    count(0, 255, hi);
    chk("R4", hi, 200, "n=200 before boundary write");
    wr(0, 0, cw(1, 20, 1));
    count(0, 256, hi);
    chk("R9", hi, 20, "write on boundary edge applies now");
  endtask

  task automatic t_multi();
    int h0, h2;
    do_reset();
    wr(0, 0, cw(1, 64, 1));
    wr(2, 0, cw(1, 128, 2));
    h0 = 0; h2 = 0;
    for (int k = 0; k < 512; k++) begin
      h0 += pwm_out[0];
      h2 += pwm_out[2];
      @(negedge clk);
    end
    chk("R1", h0, 128, "channel 0 over 512 clocks");
    chk("R1", h2, 256, "channel 2 over 512 clocks");
    chk("R1", {pwm_out[3], pwm_out[1]}, 0, "idle channels stay low");
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_duty();
    t_div();
    t_disable();
    t_midperiod();
    t_boundary();
    t_multi();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule